// File: doc/BRIEF.md
# Parallel BCH Syndrome Generator

This block reads a received binary BCH codeword over GF(2^M) at P bits per clock and produces the 2T syndromes S1 to S2T that an error-locator solver needs. The codeword arrives as a stream of P-bit beats. The highest polynomial degree comes first, and a start strobe marks the first beat of each word. The block keeps one accumulator for each odd syndrome index. On every accepted beat, each accumulator multiplies its own value by a constant and then adds the beat bits, each weighted by a constant. This is Horner's rule applied P degrees at a time.

Even-indexed syndromes are not accumulated. For a binary code S(2i) = S(i)^2, so each even syndrome is formed by repeatedly squaring an odd one. This halves the number of accumulators.

The shortened length N does not need to be a multiple of P. The first beat carries the padding in its upper bit positions, and the block discards those bits. One clock after the final beat is accepted, a done pulse rises and all syndromes are valid on the output. They hold there until the next word completes. The field polynomial, M, T, P and N are parameters.

Top module: `bch_syndrome_par`

## Requirements
- R1: While reset is low and on the first cycle after it, `syn_done` is 0 and every bit of `syn_out` is 0.
- R2: A codeword whose bits are all zero yields all 2T syndromes equal to zero.
- R3: For odd i, S(i) equals the GF(2^M) sum of alpha^(i*j) over every degree j whose received bit is 1. Alpha is the element x modulo the field polynomial, whose bit M is set. Beats arrive highest degree first. Within a beat, data bit k carries degree base+k, where base = (NBEAT-1-b)*P for beat b (0-based) and NBEAT = ceil(N/P).
- R4: For even i, S(i) equals the same sum as R3 evaluated at index i. Syndrome S(i) appears on `syn_out[(i-1)*M +: M]` for i = 1..2T.
- R5: In the first beat, data bits that map to a degree of N or above are ignored. Driving them to 1 changes no syndrome.
- R6: `syn_done` is high for exactly one cycle, the cycle after the final beat is accepted. In that same cycle `syn_out` already shows the new syndromes. `syn_out` then holds its value until the next `syn_done`.
- R7: A beat with both `beat_valid` and `beat_sof` high starts a new codeword. It discards any partial word, including one that was in progress.
- R8: Cycles with `beat_valid` low change nothing. A word delivered with idle gaps yields the same syndromes as one delivered without gaps.
- R9: A valid beat with `beat_sof` low that arrives outside a codeword is ignored. It raises no `syn_done` and leaves `syn_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| beat_valid | input | 1 | Beat present on `beat_data` |
| beat_sof | input | 1 | Beat is the first of a codeword |
| beat_data | input | P | Codeword bits; bit k carries degree base+k |
| syn_done | output | 1 | One-cycle pulse: syndromes updated |
| syn_out | output | 2*T*M | S1..S2T, S(i) at bits (i-1)*M +: M |

## Verification
The bench aims at the degree-ordering corners. A single 1 at degree 0 must make every syndrome equal to 1, and a single 1 at degree N-1 tests the far end of the word. A design that reversed the bits within a beat, or that put the padding in the last beat, would give wrong values in both cases. The padding bits are driven to 1, which exposes a design that fails to mask them. Idle gaps, an abandoned partial word followed by a restart, and stray beats outside any word check that the done pulse and the held outputs follow only accepted beats. A done pulse that comes one cycle late or early, or outputs that change without a done pulse, fail these checks. Dense random words compare the squared even syndromes with a direct per-index sum, which catches an error in the squaring chain such as S8 taken from S2 squared only once.

// File: rtl/bch_syn_pkg.sv
// Package bch_syn_pkg
// Purpose: GF(2^m) arithmetic helpers shared by the syndrome generator.
// Assumes: m <= 31. poly holds the full field polynomial including bit m.
//          Operands are already reduced (below 2^m).
package bch_syn_pkg;

    // Multiply two field elements, shift-and-add with reduction.
    function automatic logic [31:0] gf_mul(input logic [31:0] a, input logic [31:0] b,
                                           input int m, input logic [31:0] poly);
        logic [31:0] acc;
        logic [31:0] x;
        acc = '0;
        x   = a;
        for (int k = 0; k < 32; k++) begin
            if (k < m) begin
                if (b[k]) acc = acc ^ x;
                x = x << 1;
                if (x[m[4:0]]) x = x ^ poly;
            end
        end
        return acc;
    endfunction

    // alpha^e by square-and-multiply, with alpha = x.
    function automatic logic [31:0] gf_pow(input logic [31:0] e, input int m,
                                           input logic [31:0] poly);
        logic [31:0] r;
        logic [31:0] b;
        r = 32'd1;
        b = 32'd2;
        for (int k = 0; k < 32; k++) begin
            if (e[k]) r = gf_mul(r, b, m, poly);
            b = gf_mul(b, b, m, poly);
        end
        return r;
    endfunction

    // Square a field element n times.
    function automatic logic [31:0] gf_sq_n(input logic [31:0] a, input int n, input int m,
                                            input logic [31:0] poly);
        logic [31:0] r;
        r = a;
        for (int k = 0; k < 32; k++) begin
            if (k < n) r = gf_mul(r, r, m, poly);
        end
        return r;
    endfunction

    // Number of trailing zero bits of a positive integer.
    function automatic int trail_zeros(input int v);
        int c;
        int w;
        c = 0;
        w = v;
        for (int k = 0; k < 31; k++) begin
            if (w != 0 && w % 2 == 0) begin
                c = c + 1;
                w = w / 2;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/bch_syn_ctrl.sv
// Module bch_syn_ctrl
// Purpose: Tracks beats within a codeword. Decides which beats are accepted,
//          flags the final beat and produces the registered done pulse.
// Assumes: NBEAT >= 1. A beat with sof always (re)starts a word.
//          A non-sof beat outside a word is dropped.
module bch_syn_ctrl #(
    parameter int NBEAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic beat_valid,
    input  logic beat_sof,
    output logic accept,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(NBEAT + 1);

    logic          active;
    logic [CW-1:0] cnt;

    // Acceptance and final-beat detection.
    always_comb begin
        accept = beat_valid && (beat_sof || active);
        if (beat_sof) last = accept && (NBEAT == 1);
        else          last = accept && (cnt == CW'(NBEAT - 1));
    end

    // Beat counter, in-word flag and done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
            done   <= 1'b0;
        end else begin
            done <= last;
            if (accept) begin
                if (last) begin
                    active <= 1'b0;
                    cnt    <= '0;
                end else begin
                    active <= 1'b1;
                    cnt    <= beat_sof ? CW'(1) : cnt + CW'(1);
                end
            end
        end
    end

    // R6: the counter stays inside the word length.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(NBEAT));

    // R6: a done pulse follows an accepted beat.
    p_done_after_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(accept));

    // R9: a stray beat outside a word raises no done.
    p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_sof && !active) |=> !done);

endmodule

// File: rtl/bch_syn_cell.sv
// Module bch_syn_cell
// Purpose: One odd-index syndrome accumulator, P bits per beat, Horner style.
//          next = (clr ? 0 : acc*alpha^(P*IDX)) + sum_k din[k]*alpha^(k*IDX)
// Assumes: din bit k holds the degree k above the beat base.
//          Higher-degree beats arrive earlier.
module bch_syn_cell #(
    parameter int          M    = 14,
    parameter int          P    = 4,
    parameter int          IDX  = 1,
    parameter logic [31:0] POLY = 32'h4443
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [P-1:0] din,
    output logic [M-1:0] acc_nxt
);
    import bch_syn_pkg::*;

    localparam logic [31:0] FB = gf_pow(32'(P * IDX), M, POLY);

    logic [M-1:0] acc_q;
    logic [M-1:0] term [P];
    logic [M-1:0] contrib;

    // Per-bit constant weights alpha^(k*IDX).
    for (genvar k = 0; k < P; k++) begin : g_w
        localparam logic [31:0] WK = gf_pow(32'(k * IDX), M, POLY);
        assign term[k] = din[k] ? WK[M-1:0] : '0;
    end

    // Sum of the weighted beat bits plus the scaled feedback.
    always_comb begin
        contrib = '0;
        for (int k = 0; k < P; k++) contrib = contrib ^ term[k];
        acc_nxt = clr ? contrib
                      : (M'(gf_mul(32'(acc_q), FB, M, POLY)) ^ contrib);
    end

    // Accumulator register, updates only on accepted beats.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_nxt;
    end

    // R8: idle cycles leave the accumulator untouched.
    p_acc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_q));

endmodule

// File: rtl/bch_syn_expand.sv
// Module bch_syn_expand
// Purpose: Builds all 2T syndromes from the T odd ones. S(i) with i = o*2^z
//          (o odd) is S(o) squared z times.
// Assumes: odd input word j holds S(2j+1).
module bch_syn_expand #(
    parameter int          M    = 14,
    parameter int          T    = 5,
    parameter logic [31:0] POLY = 32'h4443
) (
    input  logic [T*M-1:0]   odd_syn,
    output logic [2*T*M-1:0] all_syn
);
    import bch_syn_pkg::*;

    // One slot per index, squaring depth fixed per index.
    for (genvar i = 1; i <= 2 * T; i++) begin : g_s
        localparam int Z = trail_zeros(i);
        localparam int O = i >> Z;
        if (Z == 0) begin : g_odd
            assign all_syn[(i-1)*M +: M] = odd_syn[((O-1)/2)*M +: M];
        end else begin : g_even
            assign all_syn[(i-1)*M +: M] =
                M'(gf_sq_n(32'(odd_syn[((O-1)/2)*M +: M]), Z, M, POLY));
        end
    end

endmodule

// File: rtl/bch_syndrome_par.sv
// Module bch_syndrome_par
// Purpose: Top of the P-bit-per-cycle BCH syndrome generator. Masks the front
//          padding, runs T odd accumulators, latches their final values and
//          expands them to 2T syndromes.
// Assumes: ceil(N/P) beats per word, highest degree first. Padding sits in
//          the top bits of the first beat.
module bch_syndrome_par #(
    parameter int          M    = 14,
    parameter int          T    = 5,
    parameter int          P    = 4,
    parameter int          N    = 8262,
    parameter logic [31:0] POLY = 32'h4443
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_valid,
    input  logic             beat_sof,
    input  logic [P-1:0]     beat_data,
    output logic             syn_done,
    output logic [2*T*M-1:0] syn_out
);
    localparam int NBEAT = (N + P - 1) / P;
    localparam int PAD   = NBEAT * P - N;

    logic           accept;
    logic           last;
    logic [P-1:0]   pad_mask;
    logic [P-1:0]   din_eff;
    logic [T*M-1:0] nxt;
    logic [T*M-1:0] odd_q;

    // Bits at or above degree N in the first beat are padding.
    for (genvar k = 0; k < P; k++) begin : g_mask
        assign pad_mask[k] = (k < P - PAD);
    end

    // Drop padding bits on the first beat.
    always_comb din_eff = beat_sof ? (beat_data & pad_mask) : beat_data;

    bch_syn_ctrl #(.NBEAT(NBEAT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (beat_valid),
        .beat_sof   (beat_sof),
        .accept     (accept),
        .last       (last),
        .done       (syn_done)
    );

    for (genvar j = 0; j < T; j++) begin : g_cell
        bch_syn_cell #(.M(M), .P(P), .IDX(2 * j + 1), .POLY(POLY)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (accept),
            .clr     (beat_sof),
            .din     (din_eff),
            .acc_nxt (nxt[j*M +: M])
        );
    end

    // Capture the finished odd syndromes with the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n)    odd_q <= '0;
        else if (last) odd_q <= nxt;
    end

    bch_syn_expand #(.M(M), .T(T), .POLY(POLY)) u_expand (
        .odd_syn (odd_q),
        .all_syn (syn_out)
    );

    // R6: outputs move only in a done cycle.
    p_out_change_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(odd_q) |-> syn_done);

endmodule

// File: tb/bch_syndrome_par_bench.sv
// Bench for bch_syndrome_par: directed corners plus seeded random words,
// compared with a direct per-index syndrome sum.
module bch_syndrome_par_bench;
    localparam int          M     = 14;
    localparam int          T     = 5;
    localparam int          P     = 4;
    localparam int          N     = 8262;
    localparam logic [31:0] POLY  = 32'h4443;
    localparam int          NBEAT = (N + P - 1) / P;
    localparam int          SW    = 2 * T * M;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          beat_valid = 1'b0;
    logic          beat_sof = 1'b0;
    logic [P-1:0]  beat_data = '0;
    logic          syn_done;
    logic [SW-1:0] syn_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0]  cw;
    logic [M-1:0]  exp_s [1:2*T];
    logic [SW-1:0] saved;
    bit            early_done;

    always #4 clk = ~clk;

    bch_syndrome_par #(.M(M), .T(T), .P(P), .N(N), .POLY(POLY)) u_bch_syndrome_par (
        .clk(clk), .rst_n(rst_n), .beat_valid(beat_valid), .beat_sof(beat_sof),
        .beat_data(beat_data), .syn_done(syn_done), .syn_out(syn_out)
    );

    // Field multiply, most significant multiplier bit first.
    function automatic logic [M-1:0] b_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M:0] r;
        r = '0;
        for (int k = M - 1; k >= 0; k--) begin
            r = r << 1;
            if (r[M]) r = r ^ POLY[M:0];
            if (b[k]) r = r ^ {1'b0, a};
        end
        return r[M-1:0];
    endfunction

    // Expected S1..S2T by summing alpha^(i*j) over the set bits.
    task automatic build_expected();
        for (int i = 1; i <= 2 * T; i++) begin
            logic [M-1:0] step;
            logic [M-1:0] pw;
            logic [M-1:0] s;
            step = M'(1);
            for (int r = 0; r < i; r++) step = b_mul(step, M'(2));
            pw = M'(1);
            s  = '0;
            for (int j = 0; j < N; j++) begin
                if (cw[j]) s = s ^ pw;
                pw = b_mul(pw, step);
            end
            exp_s[i] = s;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic check_syn(input string req);
        for (int i = 1; i <= 2 * T; i++)
            chk(req, 32'(syn_out[(i-1)*M +: M]), 32'(exp_s[i]));
    endtask

    // Deliver cw as a full word; gap_pct percent idle cycles; pad bits value.
    task automatic send_cw(input int gap_pct, input bit pad_ones);
        early_done = 1'b0;
        for (int b = 0; b < NBEAT; b++) begin
            int base;
            base = (NBEAT - 1 - b) * P;
            while (int'($urandom % 100) < gap_pct) begin
                @(negedge clk);
                if (syn_done) early_done = 1'b1;
                beat_valid = 1'b0;
                beat_sof   = 1'b0;
                beat_data  = P'($urandom);
            end
            @(negedge clk);
            if (syn_done && b > 0) early_done = 1'b1;
            beat_valid = 1'b1;
            beat_sof   = (b == 0);
            for (int k = 0; k < P; k++)
                beat_data[k] = (base + k < N) ? cw[base + k] : pad_ones;
        end
        @(negedge clk);
        beat_valid = 1'b0;
        beat_sof   = 1'b0;
    endtask

    task automatic random_cw();
        for (int j = 0; j < N; j++) cw[j] = 1'($urandom);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 done in reset", 32'(syn_done), 0);
        chk("R1 syn in reset", 32'(syn_out != '0), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(syn_done), 0);
        chk("R1 syn after reset", 32'(syn_out != '0), 0);

        // R2: all-zero codeword.
        cw = '0; build_expected();
        send_cw(0, 1'b0);
        chk("R6 done pulse", 32'(syn_done), 1);
        check_syn("R2 zero word");

        // R3: single 1 at degree 0 -> every syndrome is 1.
        cw = '0; cw[0] = 1'b1; build_expected();
        send_cw(0, 1'b0);
        chk("R6 done pulse", 32'(syn_done), 1);
        check_syn("R3 degree 0");
        for (int i = 1; i <= 2 * T; i++) chk("R3 unit", 32'(exp_s[i]), 1);

        // R3: single 1 at the highest degree.
        cw = '0; cw[N-1] = 1'b1; build_expected();
        send_cw(0, 1'b0);
        check_syn("R3 degree N-1");

        // R4: sparse error pattern.
        cw = '0;
        for (int e = 0; e < 5; e++) cw[$urandom % N] = 1'b1;
        build_expected();
        send_cw(0, 1'b0);
        check_syn("R4 sparse");

        // R4/R8: dense random words with idle gaps.
        for (int w = 0; w < 3; w++) begin
            random_cw(); build_expected();
            send_cw(30, 1'b0);
            chk("R6 done pulse", 32'(syn_done), 1);
            chk("R6 no early done", 32'(early_done), 0);
            check_syn("R8 gapped dense");
        end

        // R5: padding bits driven high.
        random_cw(); build_expected();
        send_cw(0, 1'b1);
        check_syn("R5 pad ignored");

        // R6: pulse lasts one cycle; outputs held.
        saved = syn_out;
        @(negedge clk);
        chk("R6 single pulse", 32'(syn_done), 0);
        repeat (5) @(negedge clk);
        chk("R6 hold", 32'(syn_out == saved), 1);

        // R7: abandon a partial word, then restart.
        early_done = 1'b0;
        for (int b = 0; b < 100; b++) begin
            @(negedge clk);
            if (syn_done) early_done = 1'b1;
            beat_valid = 1'b1;
            beat_sof   = (b == 0);
            beat_data  = P'($urandom);
        end
        @(negedge clk);
        beat_valid = 1'b0; beat_sof = 1'b0;
        chk("R7 no done on partial", 32'(early_done | syn_done), 0);
        chk("R6 hold over partial", 32'(syn_out == saved), 1);
        random_cw(); build_expected();
        send_cw(10, 1'b0);
        check_syn("R7 restart");

        // R9: stray beats outside a word.
        saved = syn_out;
        @(negedge clk);
        early_done = 1'b0;
        for (int b = 0; b < 20; b++) begin
            @(negedge clk);
            if (syn_done) early_done = 1'b1;
            beat_valid = 1'b1; beat_sof = 1'b0; beat_data = P'($urandom);
        end
        @(negedge clk);
        beat_valid = 1'b0;
        if (syn_done) early_done = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 stray no done", 32'(early_done | syn_done), 0);
        chk("R9 stray no change", 32'(syn_out == saved), 1);
        cw = '0; cw[7] = 1'b1; cw[N-2] = 1'b1; build_expected();
        send_cw(0, 1'b0);
        check_syn("R9 word after stray");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule